// File: doc/BRIEF.md
# Next Program Counter Selector

This combinational block decides where instruction fetch goes after the current instruction of a 32-bit fixed-width instruction set. It takes the address of the current instruction, a decoded control-flow kind, the two register operands that the instruction read, the 16-bit branch offset field and the 26-bit jump index field. It returns the address of the next instruction. For a call it also returns a link-write request, the link register number and the return address.

Decode feeds it in the same cycle and fetch uses its result. Straight-line code advances by one instruction. Conditional branches compare the two operands for equality or inequality and move by a signed count of instructions, counted from the instruction that follows. Jumps and calls scale a word index into a byte address inside the current 256 MiB region. A register jump returns to an address that was computed earlier.

Top module: `nxpc_unit`

## Requirements
- R1: With `flow_kind` = 0 (sequential), `next_pc` equals `cur_pc + 4`, wrapping modulo 2^32.
- R2: With `flow_kind` = 1 (branch if equal), `next_pc` is `cur_pc + 4 + 4*sext(br_imm)` when `opnd_a == opnd_b`, and `cur_pc + 4` otherwise.
- R3: With `flow_kind` = 2 (branch if not equal), `next_pc` is the same branch target when `opnd_a != opnd_b`, and `cur_pc + 4` otherwise.
- R4: `br_imm` is a two's-complement instruction count. Bit 15 set means a backward move, so 16'hFFFF on a taken branch gives `next_pc == cur_pc`.
- R5: With `flow_kind` = 3 (jump), `next_pc` is `{pc4[31:28], jmp_index, 2'b00}`, where pc4 = `cur_pc + 4`. An index of 2500 in region 0 gives 10000.
- R6: With `flow_kind` = 4 (call), `next_pc` is the jump target of R5, `link_we` is 1, `link_idx` is 31 and `link_data` is `cur_pc + 4`.
- R7: With `flow_kind` = 5 (register jump), `next_pc` equals `opnd_a` unchanged.
- R8: `link_we` is 0 for every `flow_kind` other than 4. `link_idx` is always 31 and `link_data` is always `cur_pc + 4`.
- R9: `flow_kind` codes 6 and 7 are reserved and behave as sequential: `next_pc = cur_pc + 4`, `link_we = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_pc | input | 32 | Byte address of the current instruction |
| flow_kind | input | 3 | Decoded control-flow kind (codes in R1 to R9) |
| opnd_a | input | 32 | First register operand; the target for a register jump |
| opnd_b | input | 32 | Second register operand |
| br_imm | input | 16 | Signed branch offset, in instructions |
| jmp_index | input | 26 | Word index of the jump target |
| next_pc | output | 32 | Byte address of the next instruction |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Register number that receives the return address |
| link_data | output | 32 | Return address, `cur_pc + 4` |

## Verification
The immediate assertions assume that every input carries a known value whenever the combinational logic settles. They do not require `cur_pc` or `opnd_a` to be word aligned, because a register jump passes `opnd_a` through unchanged. The bench drives every input together from a task, waits one time unit before sampling, and never leaves an input undriven. Its stimulus includes unaligned and wrap-around addresses, both offset signs, and the reserved kind codes.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    localparam int ADDR_W      = 32;
    localparam int OFFS_W      = 16;
    localparam int INDEX_W     = 26;
    localparam int INSN_BYTES  = 4;
    localparam int REGNUM_W    = 5;
    localparam int RET_REG     = 31;
    localparam int KIND_W      = 3;

    typedef enum logic [KIND_W-1:0] {
        FK_SEQ  = 3'd0,
        FK_BEQ  = 3'd1,
        FK_BNE  = 3'd2,
        FK_JMP  = 3'd3,
        FK_CALL = 3'd4,
        FK_JREG = 3'd5,
        FK_RSV6 = 3'd6,
        FK_RSV7 = 3'd7
    } flow_kind_e;

    typedef enum logic [1:0] {
        SRC_STEP   = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_REGION = 2'd2,
        SRC_REG    = 2'd3
    } pc_src_e;

    function automatic logic is_cond_branch(input flow_kind_e k);
        return (k == FK_BEQ) || (k == FK_BNE);
    endfunction

    function automatic logic is_region_jump(input flow_kind_e k);
        return (k == FK_JMP) || (k == FK_CALL);
    endfunction

endpackage

// File: rtl/nxpc_step_adder.sv
module nxpc_step_adder #(
    parameter int XLEN       = nxpc_pkg::ADDR_W,
    parameter int STEP_BYTES = nxpc_pkg::INSN_BYTES
) (
    input  logic [XLEN-1:0] pc_in,
    output logic [XLEN-1:0] pc_step
);
    localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

    always_comb begin
        pc_step = pc_in + STEP;
    end
endmodule

// File: rtl/nxpc_branch_unit.sv
module nxpc_branch_unit
    import nxpc_pkg::*;
#(
    parameter int XLEN       = ADDR_W,
    parameter int IMM_W      = OFFS_W,
    parameter int STEP_BYTES = INSN_BYTES
) (
    input  flow_kind_e      kind,
    input  logic [XLEN-1:0] base_pc,
    input  logic [IMM_W-1:0] offset,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic            taken,
    output logic [XLEN-1:0] target
);
    localparam int SHIFT = $clog2(STEP_BYTES);
    localparam int EXT_W = XLEN - IMM_W - SHIFT;

    logic [XLEN-1:0] byte_offs;
    logic            same;

    generate
        if (EXT_W > 0) begin : g_extend
            assign byte_offs = {{EXT_W{offset[IMM_W-1]}}, offset, {SHIFT{1'b0}}};
        end else begin : g_trunc
            logic [IMM_W+SHIFT-1:0] wide;
            assign wide      = {offset, {SHIFT{1'b0}}};
            assign byte_offs = wide[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        same   = (lhs == rhs);
        target = base_pc + byte_offs;
        unique case (kind)
            FK_BEQ:  taken = same;
            FK_BNE:  taken = !same;
            default: taken = 1'b0;
        endcase
    end

    // R2 / R3: a taken branch only arises from a conditional kind whose compare agrees
    always_comb begin
        if (taken) begin
            a_r2_taken_kind: assert (is_cond_branch(kind))
                else $error("taken without a conditional branch kind");
            a_r3_taken_sense: assert ((kind == FK_BEQ) == (lhs == rhs))
                else $error("branch sense mismatch");
        end
    end
endmodule

// File: rtl/nxpc_jump_unit.sv
module nxpc_jump_unit #(
    parameter int XLEN       = nxpc_pkg::ADDR_W,
    parameter int IDX_W      = nxpc_pkg::INDEX_W,
    parameter int STEP_BYTES = nxpc_pkg::INSN_BYTES
) (
    input  logic [XLEN-1:0]  base_pc,
    input  logic [IDX_W-1:0] index,
    output logic [XLEN-1:0]  target
);
    localparam int SHIFT = $clog2(STEP_BYTES);
    localparam int HI_W  = XLEN - IDX_W - SHIFT;

    generate
        if (HI_W > 0) begin : g_region
            assign target = {base_pc[XLEN-1 -: HI_W], index, {SHIFT{1'b0}}};
        end else begin : g_flat
            logic [IDX_W+SHIFT-1:0] wide;
            assign wide   = {index, {SHIFT{1'b0}}};
            assign target = wide[XLEN-1:0];
        end
    endgenerate

    // R5: target keeps instruction alignment
    always_comb begin
        a_r5_aligned: assert (target[SHIFT-1:0] == '0)
            else $error("jump target not aligned");
    end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter int XLEN       = ADDR_W,
    parameter int IMM_W      = OFFS_W,
    parameter int IDX_W      = INDEX_W,
    parameter int STEP_BYTES = INSN_BYTES,
    parameter int RN_W       = REGNUM_W,
    parameter int LINK_REG   = RET_REG
) (
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [KIND_W-1:0] flow_kind,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [IMM_W-1:0]  br_imm,
    input  logic [IDX_W-1:0]  jmp_index,
    output logic [XLEN-1:0]   next_pc,
    output logic              link_we,
    output logic [RN_W-1:0]   link_idx,
    output logic [XLEN-1:0]   link_data
);
    localparam int SHIFT = $clog2(STEP_BYTES);
    localparam int HI_W  = XLEN - IDX_W - SHIFT;

    flow_kind_e      kind;
    pc_src_e         src;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic            br_taken;

    assign kind = flow_kind_e'(flow_kind);

    nxpc_step_adder #(.XLEN(XLEN), .STEP_BYTES(STEP_BYTES)) u_step (
        .pc_in   (cur_pc),
        .pc_step (pc_seq)
    );

    nxpc_branch_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .STEP_BYTES(STEP_BYTES)) u_branch (
        .kind    (kind),
        .base_pc (pc_seq),
        .offset  (br_imm),
        .lhs     (opnd_a),
        .rhs     (opnd_b),
        .taken   (br_taken),
        .target  (br_target)
    );

    nxpc_jump_unit #(.XLEN(XLEN), .IDX_W(IDX_W), .STEP_BYTES(STEP_BYTES)) u_jump (
        .base_pc (pc_seq),
        .index   (jmp_index),
        .target  (jmp_target)
    );

    always_comb begin
        src = SRC_STEP;
        if (br_taken)                  src = SRC_BRANCH;
        else if (is_region_jump(kind)) src = SRC_REGION;
        else if (kind == FK_JREG)      src = SRC_REG;
    end

    always_comb begin
        unique case (src)
            SRC_BRANCH: next_pc = br_target;
            SRC_REGION: next_pc = jmp_target;
            SRC_REG:    next_pc = opnd_a;
            default:    next_pc = pc_seq;
        endcase
    end

    assign link_we   = (kind == FK_CALL);
    assign link_idx  = RN_W'(LINK_REG);
    assign link_data = pc_seq;

    always_comb begin
        if (kind == FK_SEQ || kind == FK_RSV6 || kind == FK_RSV7) begin
            a_r1_step: assert (next_pc == cur_pc + XLEN'(STEP_BYTES))
                else $error("sequential step wrong");
        end
        if (kind == FK_JREG) begin
            a_r7_reg_jump: assert (next_pc == opnd_a)
                else $error("register jump target wrong");
        end
        if (link_we) begin
            a_r6_link_value: assert (link_data == cur_pc + XLEN'(STEP_BYTES) && next_pc == jmp_target)
                else $error("call link or target wrong");
        end
        if (is_region_jump(kind) && HI_W > 0) begin
            a_r5_region: assert (next_pc[XLEN-1 -: 4] == link_data[XLEN-1 -: 4])
                else $error("jump left its region");
        end
        if (is_cond_branch(kind) && !br_taken) begin
            a_r2_fall: assert (next_pc == link_data)
                else $error("untaken branch not sequential");
        end
    end
endmodule

// File: tb/nxpc_unit_tb.sv
module nxpc_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] cur_pc = '0, opnd_a = '0, opnd_b = '0;
    logic [2:0]  flow_kind = '0;
    logic [15:0] br_imm = '0;
    logic [25:0] jmp_index = '0;
    logic [31:0] next_pc, link_data;
    logic        link_we;
    logic [4:0]  link_idx;
    int          total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nxpc_unit u_dut (
        .cur_pc(cur_pc), .flow_kind(flow_kind), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .br_imm(br_imm), .jmp_index(jmp_index), .next_pc(next_pc),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] k, input logic [31:0] pc, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] imm, input logic [25:0] idx);
        @(negedge clk);
        flow_kind = k; cur_pc = pc; opnd_a = a; opnd_b = b; br_imm = imm; jmp_index = idx;
        #1;
    endtask

    function automatic logic [31:0] br_tgt(input logic [31:0] pc, input logic [15:0] imm);
        return pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    endfunction

    function automatic logic [31:0] jp_tgt(input logic [31:0] pc, input logic [25:0] idx);
        logic [31:0] p4 = pc + 32'd4;
        return {p4[31:28], idx, 2'b00};
    endfunction

    task automatic t_reset_state;
        #1;
        chk("R1 idle next_pc", next_pc, 32'd4);
        chk("R8 idle link_we", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_sequential;
        apply(3'd0, 32'h0000_1000, 32'h5, 32'h5, 16'h10, 26'h3);
        chk("R1 step", next_pc, 32'h0000_1004);
        chk("R8 no link seq", {31'd0, link_we}, 32'd0);
        apply(3'd0, 32'hFFFF_FFFC, 0, 0, 0, 0);
        chk("R1 wrap", next_pc, 32'h0000_0000);
    endtask

    task automatic t_beq;
        apply(3'd1, 32'h0000_0100, 32'hAB, 32'hAB, 16'd25, 0);
        chk("R2 beq taken", next_pc, br_tgt(32'h100, 16'd25));
        apply(3'd1, 32'h0000_0100, 32'hAB, 32'hAC, 16'd25, 0);
        chk("R2 beq fall", next_pc, 32'h0000_0104);
        chk("R8 no link beq", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_bne;
        apply(3'd2, 32'h0040_0020, 32'h1, 32'h2, 16'd7, 0);
        chk("R3 bne taken", next_pc, br_tgt(32'h0040_0020, 16'd7));
        apply(3'd2, 32'h0040_0020, 32'h9, 32'h9, 16'd7, 0);
        chk("R3 bne fall", next_pc, 32'h0040_0024);
    endtask

    task automatic t_sign;
        apply(3'd1, 32'h0000_2000, 0, 0, 16'hFFFF, 0);
        chk("R4 minus one", next_pc, 32'h0000_2000);
        apply(3'd2, 32'h0000_2000, 1, 0, 16'h8000, 0);
        chk("R4 most negative", next_pc, br_tgt(32'h2000, 16'h8000));
        apply(3'd1, 32'h0000_2000, 3, 3, 16'h7FFF, 0);
        chk("R4 most positive", next_pc, 32'h0000_2000 + 32'd4 + 32'h0001_FFFC);
    endtask

    task automatic t_jump;
        apply(3'd3, 32'h0000_0040, 0, 0, 0, 26'd2500);
        chk("R5 jump 2500", next_pc, 32'd10000);
        apply(3'd3, 32'hA123_4560, 0, 0, 0, 26'h3FF_FFFF);
        chk("R5 region kept", next_pc, jp_tgt(32'hA123_4560, 26'h3FF_FFFF));
        apply(3'd3, 32'h0FFF_FFFC, 0, 0, 0, 26'h1);
        chk("R5 region from pc4", next_pc, 32'h1000_0004);
        chk("R8 no link jump", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_call;
        apply(3'd4, 32'h2000_0010, 0, 0, 0, 26'd2500);
        chk("R6 call target", next_pc, jp_tgt(32'h2000_0010, 26'd2500));
        chk("R6 link_we", {31'd0, link_we}, 32'd1);
        chk("R6 link_idx", {27'd0, link_idx}, 32'd31);
        chk("R6 link_data", link_data, 32'h2000_0014);
    endtask

    task automatic t_jreg;
        apply(3'd5, 32'h0000_3000, 32'hDEAD_BEE2, 32'h0, 16'h4, 26'h5);
        chk("R7 reg jump", next_pc, 32'hDEAD_BEE2);
        chk("R8 no link jreg", {31'd0, link_we}, 32'd0);
        chk("R8 link_data jreg", link_data, 32'h0000_3004);
        chk("R8 link_idx jreg", {27'd0, link_idx}, 32'd31);
    endtask

    task automatic t_reserved;
        for (int c = 6; c < 8; c++) begin
            apply(3'(c), 32'h0000_0500, 32'h7, 32'h7, 16'h20, 26'h40);
            chk("R9 reserved next", next_pc, 32'h0000_0504);
            chk("R9 reserved link", {31'd0, link_we}, 32'd0);
        end
    endtask

    initial begin
        t_reset_state();
        t_sequential();
        t_beq();
        t_bne();
        t_sign();
        t_jump();
        t_call();
        t_jreg();
        t_reserved();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule